// File: doc/BRIEF.md
# SAR ADC conversion sequencer

This block holds the digital control of a 10-bit successive-approximation converter that sits behind an 8-way input multiplexer. Software enables the block and then writes a one to the start bit. That write makes the block busy. On the next rising edge of the converter clock the block latches the channel and the reference choice. It then pulses a sample-and-hold strobe. After that it walks a trial code for an external DAC from the MSB down to the LSB, and it keeps or drops each bit according to the comparator bit that comes back.

The converter clock is the system clock divided by a power of two chosen by a 3-bit field. When the conversion ends, the 10-bit code is written into a pair of 8-bit data registers. In the same system-clock edge, busy drops and a one-cycle completion pulse rises. The first conversion after the block is enabled takes longer and samples later, so that the analog side can settle.

Top module: `sar_seq`

## Requirements
- R1: The result is found MSB first, one bit per converter clock. Bit k is kept when `cmp_i` is 1 while `dac_code_o` shows the kept upper bits with bit k set. For a comparator that reports input >= trial code, the result equals the input code, including 0 and 1023.
- R2: `mux_sel_o` and `ref_sel_o` take `chan_i` and `ref_sel_i` at the converter-clock edge that starts the conversion. They hold those values until the next conversion starts, even if the inputs change.
- R3: A normal conversion lasts 13 converter clocks from the start edge to the result write. `sh_o` pulses 1.5 converter clocks after the start edge.
- R4: The first conversion after `en_i` rises (or after reset) lasts 25 converter clocks. Its `sh_o` pulse comes 13.5 converter clocks after the start edge.
- R5: A write with `start_we_i`=1 and `start_wd_i`=1 while idle and enabled sets `busy_o` in the next cycle. The conversion starts on the next rising converter-clock edge. `busy_o` stays 1 until the result is written. It clears in the same cycle that the data registers change and that `done_o` is high, and `done_o` lasts one cycle.
- R6: Writing 0 to the start bit, writing to it while `en_i`=0, or writing a 1 while busy has no effect: no busy, no extra conversion, no `done_o`.
- R7: With `left_adj_i`=0, `data_hi_o`[1:0] holds result bits 9:8, `data_hi_o`[7:2] reads 0, and `data_lo_o` holds bits 7:0. Both registers read 0 after reset.
- R8: With `left_adj_i`=1, `data_hi_o` holds result bits 9:2, `data_lo_o`[7:6] holds bits 1:0, and `data_lo_o`[5:0] reads 0. The format follows `left_adj_i` at once.
- R9: The converter clock period is 2 system clocks for `div_sel_i` 0 or 1, and 2^`div_sel_i` system clocks for values 2 to 7.
- R10: Driving `en_i` low clears `busy_o` in the next cycle and aborts the conversion without writing a result. The next conversion after re-enable uses the long first-conversion timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter enable |
| start_we_i | input | 1 | Write strobe for the start bit |
| start_wd_i | input | 1 | Value written to the start bit |
| chan_i | input | 3 | Channel select |
| ref_sel_i | input | 2 | Reference-select field |
| left_adj_i | input | 1 | 1 = left-adjusted result format |
| div_sel_i | input | 3 | Converter clock divider select |
| cmp_i | input | 1 | Comparator: 1 when input >= trial code |
| busy_o | output | 1 | Start bit read-back, 1 during a conversion |
| mux_sel_o | output | 3 | Multiplexer select for the conversion |
| ref_sel_o | output | 2 | Reference select for the conversion |
| sh_o | output | 1 | Sample-and-hold strobe, one system cycle |
| dac_code_o | output | 10 | Trial code for the DAC |
| data_hi_o | output | 8 | High data register |
| data_lo_o | output | 8 | Low data register |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The comparator is modelled from a per-channel input code. The bench converts mid-scale alternating patterns (0x2A5, 0x155, 0x0C3) and both rails (0 and 0x3FF). Each pattern exposes a different wrong keep/drop decision or a wrong bit order. Timing is measured in system cycles at dividers of 2 and 16, from the start write to the strobe and to completion. These measurements separate the 13-clock normal conversion from the 25-clock first conversion, and they show whether the divider field is decoded as required. Channel and reference changes during a conversion, aborts through the enable, and ignored start writes each confirm that the latched state and the data registers stay unchanged.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
  parameter int DIV_W = 3,
  localparam int CNT_W = (1 << DIV_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_sel_i,
  output logic             rise_o,
  output logic             fall_o
);
  logic [CNT_W-1:0] cnt_q, last, half;

  always_comb begin
    if (div_sel_i == '0) last = CNT_W'(1);
    else                 last = (CNT_W'(1) << div_sel_i) - CNT_W'(1);
    half = last >> 1;
  end

  assign rise_o = en_i && (cnt_q >= last);
  assign fall_o = en_i && (cnt_q == half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (cnt_q >= last)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/sar_core.sv
module sar_core
  import sar_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int CH_W    = 3,
  parameter int REF_W   = 2,
  parameter int NORM_SH = 1,
  parameter int INIT_SH = 13,
  localparam int CYC_W  = $clog2(INIT_SH + RES_W + 3)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_we_i,
  input  logic             start_wd_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [REF_W-1:0] ref_sel_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic [CH_W-1:0]  mux_sel_o,
  output logic [REF_W-1:0] ref_sel_o,
  output logic             sh_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic             res_we_o,
  output logic [RES_W-1:0] res_o
);
  seq_state_e       state_q;
  logic             first_q;
  logic [CYC_W-1:0] cyc_q, samp, bit_lo, bit_hi, last_cyc;
  logic [RES_W-1:0] code_q, mask_q;
  logic             in_bits;

  always_comb begin
    samp     = first_q ? CYC_W'(INIT_SH) : CYC_W'(NORM_SH);
    bit_lo   = samp + CYC_W'(1);
    bit_hi   = samp + CYC_W'(RES_W);
    last_cyc = samp + CYC_W'(RES_W + 1);
    in_bits  = (cyc_q >= bit_lo) && (cyc_q <= bit_hi);
  end

  assign busy_o     = (state_q != SEQ_IDLE);
  assign dac_code_o = code_q | mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEQ_IDLE;
      first_q   <= 1'b1;
      cyc_q     <= '0;
      code_q    <= '0;
      mask_q    <= '0;
      mux_sel_o <= '0;
      ref_sel_o <= '0;
      sh_o      <= 1'b0;
      res_we_o  <= 1'b0;
      res_o     <= '0;
    end else if (!en_i) begin
      // abort and re-arm the long first conversion
      state_q  <= SEQ_IDLE;
      first_q  <= 1'b1;
      code_q   <= '0;
      mask_q   <= '0;
      sh_o     <= 1'b0;
      res_we_o <= 1'b0;
    end else begin
      sh_o     <= 1'b0;
      res_we_o <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: if (start_we_i && start_wd_i) state_q <= SEQ_WAIT;
        SEQ_WAIT: if (rise_i) begin
          state_q   <= SEQ_RUN;
          cyc_q     <= '0;
          code_q    <= '0;
          mask_q    <= {1'b1, {(RES_W-1){1'b0}}};
          mux_sel_o <= chan_i;
          ref_sel_o <= ref_sel_i;
        end
        SEQ_RUN: begin
          if (fall_i && cyc_q == samp) sh_o <= 1'b1;
          if (rise_i) begin
            if (in_bits) begin
              if (cmp_i) code_q <= code_q | mask_q;
              mask_q <= mask_q >> 1;
            end
            if (cyc_q == last_cyc) begin
              res_o    <= code_q;
              res_we_o <= 1'b1;
              first_q  <= 1'b0;
              state_q  <= SEQ_IDLE;
            end else begin
              cyc_q <= cyc_q + CYC_W'(1);
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8,
  localparam int PAIR_W = 2 * DATA_W
) (
  input  logic [RES_W-1:0]  res_i,
  input  logic              left_adj_i,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o
);
  logic [PAIR_W-1:0] pair;

  always_comb begin
    if (left_adj_i) pair = {res_i, {(PAIR_W-RES_W){1'b0}}};
    else            pair = PAIR_W'(res_i);
  end

  assign hi_o = pair[PAIR_W-1:DATA_W];
  assign lo_o = pair[DATA_W-1:0];
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int RES_W   = 10,
  parameter int CH_W    = 3,
  parameter int REF_W   = 2,
  parameter int DIV_W   = 3,
  parameter int DATA_W  = 8,
  parameter int NORM_SH = 1,
  parameter int INIT_SH = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_we_i,
  input  logic              start_wd_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [REF_W-1:0]  ref_sel_i,
  input  logic              left_adj_i,
  input  logic [DIV_W-1:0]  div_sel_i,
  input  logic              cmp_i,
  output logic              busy_o,
  output logic [CH_W-1:0]   mux_sel_o,
  output logic [REF_W-1:0]  ref_sel_o,
  output logic              sh_o,
  output logic [RES_W-1:0]  dac_code_o,
  output logic [DATA_W-1:0] data_hi_o,
  output logic [DATA_W-1:0] data_lo_o,
  output logic              done_o
);
  logic             rise, fall;
  logic [RES_W-1:0] res;

  sar_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .en_i, .div_sel_i,
    .rise_o(rise), .fall_o(fall)
  );

  sar_core #(
    .RES_W(RES_W), .CH_W(CH_W), .REF_W(REF_W),
    .NORM_SH(NORM_SH), .INIT_SH(INIT_SH)
  ) u_core (
    .clk_i, .rst_ni, .en_i, .start_we_i, .start_wd_i, .chan_i, .ref_sel_i,
    .rise_i(rise), .fall_i(fall), .cmp_i,
    .busy_o, .mux_sel_o, .ref_sel_o, .sh_o, .dac_code_o,
    .res_we_o(done_o), .res_o(res)
  );

  sar_result #(.RES_W(RES_W), .DATA_W(DATA_W)) u_fmt (
    .res_i(res), .left_adj_i, .hi_o(data_hi_o), .lo_o(data_lo_o)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int CH_W   = 3,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              start_we_i,
  input logic              start_wd_i,
  input logic              left_adj_i,
  input logic              busy_o,
  input logic [CH_W-1:0]   mux_sel_o,
  input logic              sh_o,
  input logic              done_o,
  input logic [DATA_W-1:0] data_hi_o,
  input logic [DATA_W-1:0] data_lo_o
);
  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  busy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  // R10
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!busy_o && !done_o));
  // R2
  mux_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(sh_o)) |-> $stable(mux_sel_o));
  // R3
  sh_in_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_o |-> (busy_o && !done_o));
  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(start_we_i && start_wd_i)) |=> !busy_o);
  // R7
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && $stable(left_adj_i)) |-> $stable({data_hi_o, data_lo_o}));
endmodule

bind sar_seq sar_seq_chk #(.CH_W(CH_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_sar_seq.sv
module sim_sar_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, we = 1'b0, wd = 1'b0, ladj = 1'b0, cmp;
  logic [2:0] chan = '0, div = 3'd1;
  logic [1:0] refs = '0;
  logic       busy, sh, done;
  logic [2:0] mux;
  logic [1:0] refo;
  logic [9:0] dac;
  logic [7:0] hi, lo;
  logic [9:0] vin [8];
  int         n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  assign cmp = (vin[mux] >= dac);

  sar_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_we_i(we), .start_wd_i(wd),
    .chan_i(chan), .ref_sel_i(refs), .left_adj_i(ladj), .div_sel_i(div),
    .cmp_i(cmp), .busy_o(busy), .mux_sel_o(mux), .ref_sel_o(refo), .sh_o(sh),
    .dac_code_o(dac), .data_hi_o(hi), .data_lo_o(lo), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int div_n(input logic [2:0] d);
    return (d < 3'd2) ? 2 : (1 << d);
  endfunction

  // start one conversion and check timing, busy and result
  task automatic run_conv(input logic [2:0] ch, input bit first, input logic [9:0] exp);
    int nd = div_n(div);
    int sh_n = 0, done_n = 0;
    int lo_d, lo_s;
    bit busy_ok = 1'b1;
    @(negedge clk);
    chan = ch; we = 1'b1; wd = 1'b1;
    for (int n = 1; n <= 30 * 128; n++) begin
      @(negedge clk);
      if (n == 1) begin we = 1'b0; chk(busy == 1'b1, "R5 busy after start", busy, 1); end
      if (sh) sh_n = n;
      if (done) begin done_n = n; break; end
      if (!busy) busy_ok = 1'b0;
    end
    lo_d = (first ? 25 : 13) * nd + 2;
    lo_s = (first ? 27 : 3) * nd / 2 + 2;
    chk(busy_ok, "R5 busy held", busy_ok, 1);
    chk(done_n >= lo_d && done_n <= lo_d + nd - 1,
        first ? "R4 first length" : "R3 normal length", done_n, lo_d);
    chk(sh_n >= lo_s && sh_n <= lo_s + nd - 1,
        first ? "R4 first sample" : "R3 normal sample", sh_n, lo_s);
    chk(done_n - sh_n == 23 * nd / 2, "R9 converter period", done_n - sh_n, 23 * nd / 2);
    chk(!busy, "R5 busy clears with done", busy, 0);
    chk({hi, lo} == {6'b0, exp}, "R1 R7 result", {hi, lo}, {6'b0, exp});
    @(negedge clk);
    chk(!done, "R5 done one cycle", done, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && hi == 0 && lo == 0, "R7 reset state", {busy, done, hi, lo}, 0);
  endtask

  task automatic t_codes;
    en = 1'b1; div = 3'd1;
    run_conv(3'd2, 1'b1, 10'h2A5);
    run_conv(3'd0, 1'b0, 10'h000);
    run_conv(3'd7, 1'b0, 10'h3FF);
    div = 3'd4;
    run_conv(3'd3, 1'b0, 10'h155);
    div = 3'd0;
    run_conv(3'd1, 1'b0, 10'h0C3);
    div = 3'd1;
  endtask

  task automatic t_chan_change;
    @(negedge clk);
    chan = 3'd1; refs = 2'd2; we = 1'b1; wd = 1'b1;
    @(negedge clk); we = 1'b0;
    repeat (6) @(negedge clk);
    chan = 3'd6; refs = 2'd1;
    while (!done) @(negedge clk);
    chk(mux == 3'd1, "R2 mux kept", mux, 1);
    chk(refo == 2'd2, "R2 ref kept", refo, 2);
    chk({hi, lo} == {6'b0, vin[1]}, "R2 old channel result", {hi, lo}, vin[1]);
    run_conv(3'd6, 1'b0, vin[6]);
    chk(refo == 2'd1, "R2 new ref", refo, 1);
  endtask

  task automatic t_left;
    run_conv(3'd2, 1'b0, 10'h2A5);
    ladj = 1'b1;
    @(negedge clk);
    chk(hi == 8'hA9 && lo == 8'h40, "R8 left adjust", {hi, lo}, 16'hA940);
    ladj = 1'b0;
    @(negedge clk);
    chk(hi == 8'h02 && lo == 8'hA5, "R7 right adjust", {hi, lo}, 16'h02A5);
  endtask

  task automatic t_ignored;
    logic [15:0] keep = {hi, lo};
    int dn = 0;
    @(negedge clk); we = 1'b1; wd = 1'b0;
    @(negedge clk); we = 1'b0;
    repeat (40) begin @(negedge clk); if (busy || done) dn++; end
    chk(dn == 0 && {hi, lo} == keep, "R6 write zero", dn, 0);
    // write one while busy
    @(negedge clk); chan = 3'd0; we = 1'b1; wd = 1'b1;
    @(negedge clk); we = 1'b0;
    repeat (5) @(negedge clk);
    we = 1'b1; wd = 1'b1;
    @(negedge clk); we = 1'b0;
    while (!done) @(negedge clk);
    dn = 0;
    repeat (40) begin @(negedge clk); if (busy || done) dn++; end
    chk(dn == 0, "R6 write while busy", dn, 0);
    // write while disabled
    en = 1'b0;
    @(negedge clk); we = 1'b1; wd = 1'b1;
    @(negedge clk); we = 1'b0;
    dn = 0;
    repeat (20) begin @(negedge clk); if (busy || done) dn++; end
    chk(dn == 0, "R6 write while disabled", dn, 0);
  endtask

  task automatic t_abort;
    logic [15:0] keep;
    int dn = 0;
    en = 1'b1;
    run_conv(3'd3, 1'b1, vin[3]);
    keep = {hi, lo};
    @(negedge clk); chan = 3'd7; we = 1'b1; wd = 1'b1;
    @(negedge clk); we = 1'b0;
    repeat (10) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!busy, "R10 abort clears busy", busy, 0);
    repeat (60) begin @(negedge clk); if (done) dn++; end
    chk(dn == 0 && {hi, lo} == keep, "R10 no result on abort", dn, 0);
    en = 1'b1;
    run_conv(3'd7, 1'b1, vin[7]);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    vin[0] = 10'h000; vin[1] = 10'h0C3; vin[2] = 10'h2A5; vin[3] = 10'h155;
    vin[4] = 10'h001; vin[5] = 10'h200; vin[6] = 10'h1FE; vin[7] = 10'h3FF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_codes();
    t_chan_change();
    t_left();
    t_ignored();
    t_abort();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule